// File: doc/BRIEF.md
# Programmable Clock-Enable Tree for System, PWM and ADC Clocks

This block derives three clocks from one fast reference and two slower oscillator sources: the system clock, the PWM clock and a 16 MHz ADC clock. The block's own clock port `clk` is the PLL output (400 MHz nominal). The internal precision oscillator (16 MHz) and the main crystal oscillator arrive as one-cycle tick strobes that are already synchronised to `clk`. Each derived clock comes out as a level and as a one-cycle clock-enable strobe in the `clk` domain. Downstream logic runs on `clk` and gates its registers with the strobe.

Software sets a configuration with a single write strobe. The configuration holds the base oscillator, PLL use or bypass, a system divisor from 1 to 64, a power-of-two PWM divisor, and the crystal frequency in MHz. When the PLL is in use, its output is halved before the system divisor is applied. The ADC clock source follows a fallback rule and has no register of its own. A write that is accepted waits as pending. It takes effect at the next PWM period boundary, which is always also a system period boundary, and all counters restart together at that moment. A write that is not legal is dropped.

Top module: `clk_tree_gen`

## Requirements
- R1: After reset the block uses the internal oscillator, no PLL, system divisor 1 and PWM code 0. `sys_ce_o`, `pwm_ce_o` and `adc_ce_o` each pulse once per internal tick, and both status outputs read 0.
- R2: With `cfg_src_main_i`=1 and `cfg_use_pll_i`=0, the system strobe pulses once per main-oscillator tick, and `sys_src_o` reads 1.
- R3: With `cfg_use_pll_i`=1, the system divisor counts every second `clk` cycle (PLL divided by 2), and `sys_src_o` reads 2.
- R4: `cfg_sysdiv_m1_i` holds the divisor minus one (0..63). The system strobe period is (field+1) source ticks, up to 64.
- R5: The system level stays high for ceil(N/2) source ticks and low for floor(N/2) source ticks of each period of N.
- R6: A PWM code k from 0 to 6 makes the PWM period 2^k system periods. Every `pwm_ce_o` pulse coincides with a `sys_ce_o` pulse. A write with code 7 is dropped.
- R7: With the PLL in use, the ADC strobe period is 25 `clk` cycles, the ADC level is high for 13 of them, and `adc_src_o` reads 2.
- R8: With no PLL and `cfg_xtal_mhz_i`=16, the ADC strobe follows every main tick, and `adc_src_o` reads 1.
- R9: With no PLL and a crystal code other than 16, the ADC strobe follows every internal tick, and `adc_src_o` reads 0.
- R10: A write that selects the PLL with the main oscillator and a crystal code below 5 or above 25 is dropped, and the previous configuration stays in force.
- R11: An accepted write takes effect only at the next PWM boundary of the configuration in force. Until that boundary the outputs and the status keep the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PLL output, the reference for all logic |
| rst_n | input | 1 | Active-low synchronous reset |
| piosc_tick_i | input | 1 | One-cycle strobe per internal oscillator period |
| mosc_tick_i | input | 1 | One-cycle strobe per main oscillator period |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_src_main_i | input | 1 | 1 selects the main oscillator as base, 0 the internal one |
| cfg_use_pll_i | input | 1 | 1 routes the system clock through the PLL path |
| cfg_sysdiv_m1_i | input | 6 | System divisor minus one |
| cfg_pwm_code_i | input | 3 | PWM divisor exponent, 0..6 |
| cfg_xtal_mhz_i | input | 5 | Crystal frequency in MHz |
| sys_clk_o | output | 1 | System clock level |
| sys_ce_o | output | 1 | System clock enable strobe |
| pwm_clk_o | output | 1 | PWM clock level |
| pwm_ce_o | output | 1 | PWM clock enable strobe |
| adc_clk_o | output | 1 | ADC clock level |
| adc_ce_o | output | 1 | ADC clock enable strobe |
| sys_src_o | output | 2 | Source driving the system clock: 0 internal, 1 main, 2 PLL |
| adc_src_o | output | 2 | Source driving the ADC clock: 0 internal, 1 main, 2 PLL |

## Verification
Two events can land in the same `clk` cycle: the system divider wrapping and the PWM divider wrapping. A PWM wrap is also the moment a pending configuration is applied. The bench provokes this coincidence by running several PWM codes on top of different system divisors. At each PWM strobe it checks that the system strobe is high in that same cycle. A configuration write is also placed just after a system strobe, inside a long period, and the bench checks that the old setting survives until the boundary and that the new one appears after it.

// File: rtl/clk_tree_pkg.sv
package clk_tree_pkg;

    localparam int SYSDIV_W = 6;
    localparam int PWMCODE_W = 3;
    localparam int XTAL_W = 5;

    typedef enum logic [1:0] {
        SRC_INT  = 2'd0,
        SRC_MAIN = 2'd1,
        SRC_PLL  = 2'd2
    } src_e;

    typedef struct packed {
        logic                 src_main;
        logic                 use_pll;
        logic [SYSDIV_W-1:0]  sysdiv_m1;
        logic [PWMCODE_W-1:0] pwm_code;
        logic [XTAL_W-1:0]    xtal_mhz;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{src_main: 1'b0, use_pll: 1'b0,
                                   sysdiv_m1: '0, pwm_code: '0, xtal_mhz: '0};

endpackage

// File: rtl/clk_tree_div.sv
module clk_tree_div #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         restart_i,
    input  logic [W-1:0] div_m1_i,
    output logic         wrap_o,
    output logic         ce_o,
    output logic         lvl_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         lvl;
        logic         ce;
    } st_t;

    st_t st_d, st_q;
    logic [W:0] hi_ticks;
    logic [W-1:0] cnt_nxt;

    always_comb begin
        wrap_o   = tick_i && (st_q.cnt == div_m1_i);
        hi_ticks = ({1'b0, div_m1_i} + {{W{1'b0}}, 1'b1} + {{W{1'b0}}, 1'b1}) >> 1;
        cnt_nxt  = wrap_o ? '0 : st_q.cnt + {{(W-1){1'b0}}, 1'b1};
        st_d     = st_q;
        st_d.ce  = wrap_o;
        if (restart_i) begin
            st_d.cnt = '0;
            st_d.lvl = 1'b1;
        end else if (tick_i) begin
            st_d.cnt = cnt_nxt;
            st_d.lvl = ({1'b0, cnt_nxt} < hi_ticks);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, lvl: 1'b1, ce: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ce_o  = st_q.ce;
    assign lvl_o = (div_m1_i == '0) ? st_q.ce : st_q.lvl;

    // R4: a strobe only ever follows a source tick
    p_ce_after_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ce |-> $past(tick_i));

    // R5: the level moves only on a tick or a restart
    p_lvl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !restart_i) |=> $stable(st_q.lvl));

endmodule

// File: rtl/clk_tree_cfg.sv
module clk_tree_cfg
    import clk_tree_pkg::*;
#(
    parameter int XTAL_LO  = 5,
    parameter int XTAL_HI  = 25,
    parameter int PWM_MAX  = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  cfg_t wr_cfg_i,
    input  logic boundary_i,
    output cfg_t act_o,
    output logic apply_o
);

    typedef struct packed {
        cfg_t act;
        cfg_t pend;
        logic pend_v;
    } st_t;

    st_t  st_d, st_q;
    logic xtal_bad;
    logic wr_ok;

    always_comb begin
        xtal_bad = (int'(wr_cfg_i.xtal_mhz) < XTAL_LO) || (int'(wr_cfg_i.xtal_mhz) > XTAL_HI);
        wr_ok    = !(wr_cfg_i.use_pll && wr_cfg_i.src_main && xtal_bad)
                   && (int'(wr_cfg_i.pwm_code) <= PWM_MAX);
        apply_o  = st_q.pend_v && boundary_i;
        st_d     = st_q;
        if (apply_o) begin
            st_d.act    = st_q.pend;
            st_d.pend_v = 1'b0;
        end
        if (wr_i && wr_ok) begin
            st_d.pend   = wr_cfg_i;
            st_d.pend_v = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{act: CFG_RESET, pend: CFG_RESET, pend_v: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign act_o = st_q.act;

    // R11: the active setting changes only right after a boundary
    p_change_at_boundary_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act != $past(st_q.act)) |-> $past(boundary_i));

    // R10: an active PLL-with-main setting always carries a legal crystal code
    p_xtal_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act.use_pll && st_q.act.src_main) |->
            (int'(st_q.act.xtal_mhz) >= XTAL_LO && int'(st_q.act.xtal_mhz) <= XTAL_HI));

endmodule

// File: rtl/clk_tree_gen.sv
module clk_tree_gen
    import clk_tree_pkg::*;
#(
    parameter int XTAL_LO     = 5,
    parameter int XTAL_HI     = 25,
    parameter int XTAL_ADC    = 16,
    parameter int ADC_PLL_DIV = 25,
    parameter int PWM_MAX     = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 piosc_tick_i,
    input  logic                 mosc_tick_i,
    input  logic                 cfg_wr_i,
    input  logic                 cfg_src_main_i,
    input  logic                 cfg_use_pll_i,
    input  logic [SYSDIV_W-1:0]  cfg_sysdiv_m1_i,
    input  logic [PWMCODE_W-1:0] cfg_pwm_code_i,
    input  logic [XTAL_W-1:0]    cfg_xtal_mhz_i,
    output logic                 sys_clk_o,
    output logic                 sys_ce_o,
    output logic                 pwm_clk_o,
    output logic                 pwm_ce_o,
    output logic                 adc_clk_o,
    output logic                 adc_ce_o,
    output logic [1:0]           sys_src_o,
    output logic [1:0]           adc_src_o
);

    localparam int ADC_W = $clog2(ADC_PLL_DIV);

    typedef struct packed {
        logic half;
    } st_t;

    st_t  st_d, st_q;
    cfg_t wr_cfg, act;
    logic apply, boundary;
    logic sys_tick, sys_wrap, pwm_wrap, adc_tick, adc_wrap, adc_xtal_ok;
    logic [SYSDIV_W-1:0] pwm_div_m1;
    logic [ADC_W-1:0]    adc_div_m1;

    assign wr_cfg = '{src_main: cfg_src_main_i, use_pll: cfg_use_pll_i,
                      sysdiv_m1: cfg_sysdiv_m1_i, pwm_code: cfg_pwm_code_i,
                      xtal_mhz: cfg_xtal_mhz_i};

    clk_tree_cfg #(.XTAL_LO(XTAL_LO), .XTAL_HI(XTAL_HI), .PWM_MAX(PWM_MAX)) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr_i), .wr_cfg_i(wr_cfg),
        .boundary_i(boundary), .act_o(act), .apply_o(apply)
    );

    always_comb begin
        st_d.half   = act.use_pll ? ~st_q.half : 1'b0;
        sys_tick    = act.use_pll ? st_q.half : (act.src_main ? mosc_tick_i : piosc_tick_i);
        pwm_div_m1  = SYSDIV_W'((1 << act.pwm_code) - 1);
        adc_xtal_ok = (int'(act.xtal_mhz) == XTAL_ADC);
        if (act.use_pll) begin
            adc_tick   = 1'b1;
            adc_div_m1 = ADC_W'(ADC_PLL_DIV - 1);
            sys_src_o  = SRC_PLL;
            adc_src_o  = SRC_PLL;
        end else begin
            adc_tick   = adc_xtal_ok ? mosc_tick_i : piosc_tick_i;
            adc_div_m1 = '0;
            sys_src_o  = act.src_main ? SRC_MAIN : SRC_INT;
            adc_src_o  = adc_xtal_ok ? SRC_MAIN : SRC_INT;
        end
        boundary = pwm_wrap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{half: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    clk_tree_div #(.W(SYSDIV_W)) sys_div_i (
        .clk(clk), .rst_n(rst_n), .tick_i(sys_tick), .restart_i(apply),
        .div_m1_i(act.sysdiv_m1), .wrap_o(sys_wrap), .ce_o(sys_ce_o), .lvl_o(sys_clk_o)
    );

    clk_tree_div #(.W(SYSDIV_W)) pwm_div_i (
        .clk(clk), .rst_n(rst_n), .tick_i(sys_wrap), .restart_i(apply),
        .div_m1_i(pwm_div_m1), .wrap_o(pwm_wrap), .ce_o(pwm_ce_o), .lvl_o(pwm_clk_o)
    );

    clk_tree_div #(.W(ADC_W)) adc_div_i (
        .clk(clk), .rst_n(rst_n), .tick_i(adc_tick), .restart_i(apply),
        .div_m1_i(adc_div_m1), .wrap_o(adc_wrap), .ce_o(adc_ce_o), .lvl_o(adc_clk_o)
    );

    // R6: the PWM strobe never appears without the system strobe
    p_pwm_with_sys_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_ce_o |-> sys_ce_o);

    // R7: on the PLL path the ADC strobes are never back to back
    p_adc_pll_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_src_o == SRC_PLL && adc_ce_o) |=> !adc_ce_o);

    // R3: the two status outputs agree on whether the PLL is in use
    p_status_pll_agree_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_src_o == SRC_PLL) == (adc_src_o == SRC_PLL));

endmodule

// File: tb/clk_tree_gen_tb_top.sv
module clk_tree_gen_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic piosc_tick = 1'b0, mosc_tick = 1'b0;
    logic cfg_wr = 1'b0, cfg_src_main = 1'b0, cfg_use_pll = 1'b0;
    logic [5:0] cfg_sysdiv_m1 = '0;
    logic [2:0] cfg_pwm_code = '0;
    logic [4:0] cfg_xtal = '0;
    logic sys_clk, sys_ce, pwm_clk, pwm_ce, adc_clk, adc_ce;
    logic [1:0] sys_src, adc_src;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    clk_tree_gen dut_i (
        .clk(clk), .rst_n(rst_n), .piosc_tick_i(piosc_tick), .mosc_tick_i(mosc_tick),
        .cfg_wr_i(cfg_wr), .cfg_src_main_i(cfg_src_main), .cfg_use_pll_i(cfg_use_pll),
        .cfg_sysdiv_m1_i(cfg_sysdiv_m1), .cfg_pwm_code_i(cfg_pwm_code),
        .cfg_xtal_mhz_i(cfg_xtal),
        .sys_clk_o(sys_clk), .sys_ce_o(sys_ce), .pwm_clk_o(pwm_clk), .pwm_ce_o(pwm_ce),
        .adc_clk_o(adc_clk), .adc_ce_o(adc_ce), .sys_src_o(sys_src), .adc_src_o(adc_src)
    );

    // internal ticks every 4 cycles, main ticks every 3 cycles
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            piosc_tick = (cyc % 4 == 0);
            mosc_tick  = (cyc % 3 == 0);
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
        summary();
    end

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic ce_of(int sel);
        case (sel)
            0: return sys_ce;
            1: return pwm_ce;
            default: return adc_ce;
        endcase
    endfunction

    function automatic logic lvl_of(int sel);
        case (sel)
            0: return sys_clk;
            1: return pwm_clk;
            default: return adc_clk;
        endcase
    endfunction

    // period (clk cycles between strobes) and high cycles within that period
    task automatic measure(int sel, output int per, output int hi);
        int guard = 0;
        per = 0;
        hi = 0;
        @(negedge clk);
        while (!ce_of(sel) && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        do begin
            @(negedge clk);
            per++;
            if (lvl_of(sel)) hi++;
        end while (!ce_of(sel) && per < 5000);
    endtask

    task automatic period2(int sel, output int per, output int hi);
        int p0, h0;
        measure(sel, p0, h0);
        measure(sel, per, hi);
    endtask

    task automatic write_cfg(bit main, bit pll, int dm1, int code, int xtal);
        @(negedge clk);
        cfg_src_main  = main;
        cfg_use_pll   = pll;
        cfg_sysdiv_m1 = 6'(dm1);
        cfg_pwm_code  = 3'(code);
        cfg_xtal      = 5'(xtal);
        cfg_wr        = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic t_reset();
        int p, h;
        chk("R1 sys_src", int'(sys_src), 0);
        chk("R1 adc_src", int'(adc_src), 0);
        period2(0, p, h); chk("R1 sys period", p, 4);
        period2(1, p, h); chk("R1 pwm period", p, 4);
        period2(2, p, h); chk("R1 adc period", p, 4);
    endtask

    task automatic t_main_xtal16();
        int p, h;
        write_cfg(1, 0, 0, 0, 16);
        repeat (50) @(negedge clk);
        chk("R2 sys_src", int'(sys_src), 1);
        period2(0, p, h); chk("R2 sys period", p, 3);
        chk("R8 adc_src", int'(adc_src), 1);
        period2(2, p, h); chk("R8 adc period", p, 3);
    endtask

    task automatic t_adc_fallback();
        int p, h;
        write_cfg(1, 0, 0, 0, 10);
        repeat (50) @(negedge clk);
        chk("R9 adc_src", int'(adc_src), 0);
        period2(2, p, h); chk("R9 adc period", p, 4);
        period2(0, p, h); chk("R9 sys still main", p, 3);
    endtask

    task automatic t_pll_div5();
        int p, h;
        write_cfg(1, 1, 4, 6, 16);
        repeat (50) @(negedge clk);
        chk("R3 sys_src", int'(sys_src), 2);
        period2(0, p, h);
        chk("R3 sys period", p, 10);
        chk("R5 sys high odd", h, 6);
        period2(1, p, h); chk("R6 pwm period code6", p, 640);
        chk("R6 sys_ce with pwm_ce", int'(sys_ce), 1);
        chk("R7 adc_src", int'(adc_src), 2);
        period2(2, p, h);
        chk("R7 adc period", p, 25);
        chk("R7 adc high", h, 13);
    endtask

    task automatic t_refuse_xtal();
        int p, h;
        write_cfg(1, 1, 0, 0, 30);
        repeat (700) @(negedge clk);
        chk("R10 sys_src kept", int'(sys_src), 2);
        period2(0, p, h); chk("R10 sys period kept", p, 10);
        write_cfg(1, 1, 0, 0, 4);
        repeat (700) @(negedge clk);
        period2(0, p, h); chk("R10 low code refused", p, 10);
    endtask

    task automatic t_refuse_pwm7();
        int p, h;
        write_cfg(1, 1, 4, 7, 16);
        repeat (700) @(negedge clk);
        period2(1, p, h); chk("R6 code7 refused", p, 640);
    endtask

    task automatic t_div64();
        int p, h;
        write_cfg(0, 0, 63, 0, 0);
        repeat (800) @(negedge clk);
        chk("R4 sys_src", int'(sys_src), 0);
        period2(0, p, h);
        chk("R4 sys period 64", p, 256);
        chk("R5 sys high even", h, 128);
    endtask

    task automatic t_boundary();
        int p, h;
        int guard = 0;
        @(negedge clk);
        while (!sys_ce && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        write_cfg(0, 1, 0, 0, 0);
        repeat (40) @(negedge clk);
        chk("R11 old src before boundary", int'(sys_src), 0);
        repeat (300) @(negedge clk);
        chk("R11 new src after boundary", int'(sys_src), 2);
        period2(0, p, h); chk("R11 R3 pll div1 period", p, 2);
    endtask

    task automatic t_odd_pwm8();
        int p, h;
        write_cfg(0, 0, 2, 3, 0);
        repeat (50) @(negedge clk);
        period2(0, p, h);
        chk("R5 sys period div3", p, 12);
        chk("R5 sys high div3", h, 8);
        period2(1, p, h); chk("R6 pwm period code3", p, 96);
        chk("R6 sys_ce with pwm_ce code3", int'(sys_ce), 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_main_xtal16();
        t_adc_fallback();
        t_pll_div5();
        t_refuse_xtal();
        t_refuse_pwm7();
        t_div64();
        t_boundary();
        t_odd_pwm8();
        summary();
    end

endmodule